// File: doc/BRIEF.md
# Software-Generated Interrupt Dispatcher

This block turns software-issued inter-processor interrupt requests into per-CPU pending flags. A CPU writes a generation word that carries an interrupt number (one of 16), a two-bit target filter mode and an eight-bit CPU list. The block works out the set of receiving CPUs. For each receiver it latches that interrupt as pending and records, in a per-receiver, per-interrupt bitmap, which CPU asked for it. Receivers are limited to the CPUs that are online.

Each CPU can also reach its own source bitmaps through two 16-byte windows. Byte n of a window is the bitmap of interrupt n. A write to the clear window removes sources, and a write to the set window adds them. Byte enables allow single-byte or whole-word access. Reads of either window return the bitmaps one cycle later. The identity of the requesting or accessing CPU comes in with every bus cycle. The block accepts one bus operation per cycle, so all updates to a given entry happen in bus order.

Top module: `sgi_dispatch`

## Requirements
- R1: After reset every source bitmap and every pending flag is zero, and `bus_rdata` is zero.
- R2: A receiver index at or above `online_cnt` is never selected by a generation write in any mode. Bit i of the target mask is kept only when i < `online_cnt`.
- R3: A generation write (word address 0) with mode field `wdata[25:24]`=0 selects the CPUs listed in `wdata[23:16]` (bit i = CPU i).
- R4: Mode 1 selects every online CPU except the requester `bus_cpu`.
- R5: Mode 2 selects only the requester.
- R6: Mode 3 changes no bitmap and no pending flag.
- R7: For each selected receiver, the interrupt named by `wdata[3:0]` becomes pending, and bit `bus_cpu` is ORed into its source bitmap. Other bits of the bitmap are kept.
- R8: A read returns data in the following cycle, and `bus_rdata` is zero in every cycle that follows no read. Reads of word 0 (generation) and of unmapped words (1–3, 12–15) return zero.
- R9: A read of word 4+w (clear window) or 8+w (set window) returns, in byte k, the source bitmap of interrupt 4w+k for receiver `bus_cpu`.
- R10: A clear-window write clears the bitmap bits written as 1. When the bitmap becomes zero, the pending flag drops.
- R11: A set-window write ORs the written byte into the bitmap. The pending flag is set only if the result is nonzero.
- R12: Only byte lanes with `bus_be[k]`=1 are affected by window writes. Only the accessing CPU's bitmaps change. Writes to unmapped words have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| online_cnt | input | 4 | Number of online CPUs (1..8) |
| bus_valid | input | 1 | Bus operation this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Word address |
| bus_be | input | 4 | Byte-lane enables for window writes |
| bus_wdata | input | 32 | Write data |
| bus_cpu | input | 3 | Requesting / accessing CPU |
| bus_rdata | output | 32 | Read data, one cycle after the read |
| pend_o | output | 128 | Pending flag of receiver c, interrupt s at bit c*16+s |

## Verification
A wrong source bitmap shows at the ports in two ways. It appears on the next window read by the affected CPU. If it makes the bitmap empty or non-empty wrongly, it also shows as a `pend_o` flag that differs from the model one cycle after the write. A mistake in target selection shows at once in the receivers' pending flags. The bench therefore compares every pending flag and the read data on every cycle. It also reads back bitmaps after partial-lane and cross-CPU writes, so that stray bits are seen even when the pending flag does not change.

// File: rtl/sgi_pkg.sv
package sgi_pkg;
    localparam int NUM_CPU  = 8;
    localparam int NUM_SGI  = 16;
    localparam int LANE_W   = 8;
    localparam int LANES    = 4;
    localparam int CPU_W    = $clog2(NUM_CPU);
    localparam int SGI_W    = $clog2(NUM_SGI);
    localparam int CNT_W    = $clog2(NUM_CPU + 1);
    localparam int WORDS    = NUM_SGI / LANES;
    localparam int WORD_W   = $clog2(WORDS);

    typedef enum logic [1:0] {
        FLT_LIST    = 2'd0,
        FLT_OTHERS  = 2'd1,
        FLT_SELF    = 2'd2,
        FLT_NONE    = 2'd3
    } filter_e;

    typedef enum logic [1:0] {
        RGN_GEN,
        RGN_CLR,
        RGN_SET,
        RGN_NONE
    } region_e;
endpackage

// File: rtl/sgi_target_sel.sv
module sgi_target_sel
    import sgi_pkg::*;
(
    input  logic [1:0]       mode_i,
    input  logic [7:0]       list_i,
    input  logic [CPU_W-1:0] req_i,
    input  logic [CNT_W-1:0] online_i,
    output logic [NUM_CPU-1:0] tgt_o
);
    logic [NUM_CPU-1:0] online_mask;
    logic [NUM_CPU-1:0] req_onehot;
    logic [NUM_CPU-1:0] raw;

    for (genvar i = 0; i < NUM_CPU; i++) begin : g_mask
        assign online_mask[i] = (CNT_W'(i) < online_i);
        assign req_onehot[i]  = (req_i == CPU_W'(i));
    end

    always_comb begin
        unique case (filter_e'(mode_i))
            FLT_LIST:   raw = list_i[NUM_CPU-1:0];
            FLT_OTHERS: raw = ~req_onehot;
            FLT_SELF:   raw = req_onehot;
            default:    raw = '0;
        endcase
        tgt_o = raw & online_mask;
    end

    always_comb begin
        // R4
        if (filter_e'(mode_i) == FLT_OTHERS)
            others_excl_chk: assert (tgt_o[req_i] == 1'b0);
        // R5
        if (filter_e'(mode_i) == FLT_SELF)
            self_single_chk: assert ($countones(tgt_o) <= 1);
    end
endmodule

// File: rtl/sgi_lane_decode.sv
module sgi_lane_decode
    import sgi_pkg::*;
(
    input  logic [WORD_W-1:0]            word_i,
    input  logic [LANES-1:0]             be_i,
    input  logic [LANES*LANE_W-1:0]      wdata_i,
    output logic [NUM_SGI-1:0]           hit_o,
    output logic [NUM_SGI-1:0][LANE_W-1:0] byte_o
);
    for (genvar s = 0; s < NUM_SGI; s++) begin : g_lane
        localparam int LN = s % LANES;
        localparam int WD = s / LANES;
        assign hit_o[s]  = (word_i == WORD_W'(WD)) && be_i[LN];
        assign byte_o[s] = wdata_i[LN*LANE_W +: LANE_W];
    end
endmodule

// File: rtl/sgi_dispatch.sv
module sgi_dispatch
    import sgi_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [CNT_W-1:0]           online_cnt,
    input  logic                       bus_valid,
    input  logic                       bus_write,
    input  logic [3:0]                 bus_addr,
    input  logic [LANES-1:0]           bus_be,
    input  logic [LANES*LANE_W-1:0]    bus_wdata,
    input  logic [CPU_W-1:0]           bus_cpu,
    output logic [LANES*LANE_W-1:0]    bus_rdata,
    output logic [NUM_CPU*NUM_SGI-1:0] pend_o
);
    typedef struct packed {
        logic [NUM_CPU-1:0][NUM_SGI-1:0][NUM_CPU-1:0] src;
        logic [NUM_CPU-1:0][NUM_SGI-1:0]              pend;
        logic [LANES*LANE_W-1:0]                      rdata;
    } state_t;

    state_t st_d, st_q;
    region_e rgn;
    logic [NUM_CPU-1:0] tgt;
    logic [NUM_SGI-1:0] lane_hit;
    logic [NUM_SGI-1:0][LANE_W-1:0] lane_byte;
    logic [WORD_W-1:0] word_idx;
    logic [SGI_W-1:0] sgi_id;
    logic wr, rd;

    assign wr       = bus_valid && bus_write;
    assign rd       = bus_valid && !bus_write;
    assign word_idx = bus_addr[WORD_W-1:0];
    assign sgi_id   = bus_wdata[SGI_W-1:0];

    always_comb begin
        unique case (bus_addr[3:2])
            2'd0:    rgn = (bus_addr[1:0] == 2'd0) ? RGN_GEN : RGN_NONE;
            2'd1:    rgn = RGN_CLR;
            2'd2:    rgn = RGN_SET;
            default: rgn = RGN_NONE;
        endcase
    end

    sgi_target_sel u_tsel (
        .mode_i   (bus_wdata[25:24]),
        .list_i   (bus_wdata[23:16]),
        .req_i    (bus_cpu),
        .online_i (online_cnt),
        .tgt_o    (tgt)
    );

    sgi_lane_decode u_lanes (
        .word_i  (word_idx),
        .be_i    (bus_be),
        .wdata_i (bus_wdata),
        .hit_o   (lane_hit),
        .byte_o  (lane_byte)
    );

    always_comb begin
        logic [NUM_CPU-1:0] nb;
        logic [LANE_W-1:0]  rb;
        st_d       = st_q;
        st_d.rdata = '0;
        nb         = '0;
        rb         = '0;
        if (wr && rgn == RGN_GEN) begin
            for (int c = 0; c < NUM_CPU; c++) begin
                if (tgt[c]) begin
                    st_d.src[c][sgi_id][bus_cpu] = 1'b1;
                    st_d.pend[c][sgi_id]         = 1'b1;
                end
            end
        end
        if (wr && rgn == RGN_CLR) begin
            for (int s = 0; s < NUM_SGI; s++) begin
                if (lane_hit[s]) begin
                    nb = st_q.src[bus_cpu][s] & ~lane_byte[s][NUM_CPU-1:0];
                    st_d.src[bus_cpu][s] = nb;
                    if (nb == '0) st_d.pend[bus_cpu][s] = 1'b0;
                end
            end
        end
        if (wr && rgn == RGN_SET) begin
            for (int s = 0; s < NUM_SGI; s++) begin
                if (lane_hit[s]) begin
                    nb = st_q.src[bus_cpu][s] | lane_byte[s][NUM_CPU-1:0];
                    st_d.src[bus_cpu][s] = nb;
                    if (nb != '0) st_d.pend[bus_cpu][s] = 1'b1;
                end
            end
        end
        if (rd && (rgn == RGN_CLR || rgn == RGN_SET)) begin
            for (int k = 0; k < LANES; k++) begin
                rb = '0;
                rb[NUM_CPU-1:0] = st_q.src[bus_cpu][int'(word_idx)*LANES + k];
                st_d.rdata[k*LANE_W +: LANE_W] = rb;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bus_rdata = st_q.rdata;
    assign pend_o    = st_q.pend;

    // R6
    mode_rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && rgn == RGN_GEN && bus_wdata[25:24] == 2'd3) |=> $stable(pend_o));

    // R12
    idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr || rgn == RGN_NONE) |=> $stable(pend_o));

    // R8
    gen_raz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && rgn == RGN_GEN) |=> (bus_rdata == '0));

    // R8
    no_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> (bus_rdata == '0));

    // R10
    clr_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && rgn == RGN_CLR && bus_be == '1 && bus_wdata == '1)
        |=> (st_q.pend[$past(bus_cpu)][$past(word_idx)*LANES +: LANES] == '0));
endmodule

// File: tb/sgi_dispatch_tb_top.sv
module sgi_dispatch_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [3:0] online_cnt = 4'd8;
    logic bus_valid = 1'b0, bus_write = 1'b0;
    logic [3:0] bus_addr = '0;
    logic [3:0] bus_be = '0;
    logic [31:0] bus_wdata = '0;
    logic [2:0] bus_cpu = '0;
    logic [31:0] bus_rdata;
    logic [127:0] pend_o;

    always #2 clk = ~clk;

    sgi_dispatch dut_i (
        .clk(clk), .rst_n(rst_n), .online_cnt(online_cnt),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
        .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_cpu(bus_cpu),
        .bus_rdata(bus_rdata), .pend_o(pend_o)
    );

    int n_run = 0, n_fail = 0;
    int msrc [8][16];
    logic [31:0] exp_rdata = '0;
    string cur_req = "R1";

    task automatic compare();
        logic [127:0] ep;
        for (int c = 0; c < 8; c++)
            for (int s = 0; s < 16; s++)
                ep[c*16+s] = (msrc[c][s] != 0);
        n_run++;
        if (pend_o !== ep) begin
            n_fail++;
            $display("FAIL %s pend actual=%h expected=%h", cur_req, pend_o, ep);
        end
        n_run++;
        if (bus_rdata !== exp_rdata) begin
            n_fail++;
            $display("FAIL %s rdata actual=%h expected=%h", cur_req, bus_rdata, exp_rdata);
        end
    endtask

    // called at a negedge: drive, advance model, wait an edge, compare
    task automatic step(input logic v, input logic w, input logic [3:0] a,
                        input logic [3:0] be, input logic [31:0] d, input logic [2:0] cpu);
        int mask, tg, sg;
        bus_valid = v; bus_write = w; bus_addr = a; bus_be = be;
        bus_wdata = d; bus_cpu = cpu;
        exp_rdata = '0;
        mask = (1 << online_cnt) - 1;
        if (v && !w && (a[3:2] == 2'd1 || a[3:2] == 2'd2))
            for (int k = 0; k < 4; k++)
                exp_rdata[k*8 +: 8] = 8'(msrc[cpu][a[1:0]*4+k]);
        if (v && w && a == 4'd0) begin
            sg = int'(d[3:0]);
            case (d[25:24])
                2'd0: tg = int'(d[23:16]);
                2'd1: tg = 8'hFF & ~(1 << cpu);
                2'd2: tg = 1 << cpu;
                default: tg = 0;
            endcase
            tg = tg & mask;
            for (int c = 0; c < 8; c++)
                if (tg[c]) msrc[c][sg] = msrc[c][sg] | (1 << cpu);
        end
        if (v && w && (a[3:2] == 2'd1 || a[3:2] == 2'd2))
            for (int k = 0; k < 4; k++)
                if (be[k]) begin
                    sg = a[1:0]*4 + k;
                    if (a[3:2] == 2'd1) msrc[cpu][sg] = msrc[cpu][sg] & ~int'(d[k*8 +: 8]);
                    else                msrc[cpu][sg] = msrc[cpu][sg] | int'(d[k*8 +: 8]);
                end
        @(posedge clk);
        @(negedge clk);
        bus_valid = 1'b0;
        compare();
    endtask

    task automatic gen(input logic [2:0] cpu, input logic [3:0] id,
                       input logic [1:0] mode, input logic [7:0] lst);
        step(1, 1, 4'd0, 4'hF, {6'd0, mode, lst, 12'd0, id}, cpu);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        for (int c = 0; c < 8; c++) for (int s = 0; s < 16; s++) msrc[c][s] = 0;
        repeat (3) @(negedge clk);
        cur_req = "R1"; compare();
        rst_n = 1'b1;
        step(0, 0, 0, 0, 0, 0);
        cur_req = "R3"; gen(3'd2, 4'd5, 2'd0, 8'h81);
        cur_req = "R9"; step(1, 0, 4'd5, 4'hF, 0, 3'd0);
        step(1, 0, 4'd9, 4'hF, 0, 3'd7);
        cur_req = "R7"; gen(3'd4, 4'd5, 2'd0, 8'h01);
        step(1, 0, 4'd5, 4'hF, 0, 3'd0);
        cur_req = "R4"; gen(3'd3, 4'd0, 2'd1, 8'h00);
        step(1, 0, 4'd4, 4'hF, 0, 3'd3);
        cur_req = "R5"; gen(3'd6, 4'd15, 2'd2, 8'h00);
        step(1, 0, 4'd7, 4'hF, 0, 3'd6);
        cur_req = "R6"; gen(3'd1, 4'd1, 2'd3, 8'hFF);
        step(1, 0, 4'd4, 4'hF, 0, 3'd0);
        cur_req = "R8"; step(1, 0, 4'd0, 4'hF, 0, 3'd0);
        step(1, 0, 4'd13, 4'hF, 0, 3'd0);
        cur_req = "R11"; step(1, 1, 4'd10, 4'h1, 32'h0, 3'd4);
        step(1, 1, 4'd10, 4'h1, 32'h11, 3'd4);
        cur_req = "R12"; step(1, 1, 4'd10, 4'h2, 32'hFFFF_FFFF, 3'd4);
        step(1, 0, 4'd6, 4'hF, 0, 3'd4);
        step(1, 0, 4'd6, 4'hF, 0, 3'd0);
        step(1, 1, 4'd14, 4'hF, 32'hFFFF_FFFF, 3'd4);
        cur_req = "R10"; step(1, 1, 4'd6, 4'h1, 32'h01, 3'd4);
        step(1, 1, 4'd6, 4'h1, 32'h10, 3'd4);
        step(1, 1, 4'd6, 4'hF, 32'hFFFF_FFFF, 3'd4);
        step(1, 0, 4'd10, 4'hF, 0, 3'd4);
        cur_req = "R2"; online_cnt = 4'd3;
        gen(3'd0, 4'd3, 2'd0, 8'hFF);
        gen(3'd1, 4'd2, 2'd1, 8'h00);
        gen(3'd5, 4'd7, 2'd2, 8'h00);
        online_cnt = 4'd8;
        cur_req = "R7";
        for (int i = 0; i < 400; i++) begin
            logic [3:0] a;
            a = 4'($urandom_range(0, 15));
            if ($urandom_range(0, 2) == 0) a = 4'd0;
            online_cnt = 4'($urandom_range(1, 8));
            step(1'($urandom), 1'($urandom), a, 4'($urandom),
                 $urandom & 32'h03FF_FFFF | (32'($urandom_range(0,3)) << 24), 3'($urandom));
        end
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule